// File: doc/BRIEF.md
# Paged Expansion Address Decoder

This block sits on a host's parallel expansion bus and decodes accesses for one add-on device. The device claims a 2 KB region at $D800–$DFFF. Inside it there is a banked driver ROM, a banked scratch RAM and two 256-byte windows onto an attached card bus. The first window reaches the card's 16-bit I/O space and the second reaches its 20-bit memory space. Four registers in page $D1 hold the upper address bits. The host sets them once, then reaches any card location through the 256-byte windows.

One register, the page register, holds three things: the driver ROM page, the RAM page and card address bits 19..16. A second register, the offset register, holds card address bits 15..8. A control register switches the device on and off. While the device is on, the block raises a pin that tells the host to give up its built-in math ROM in the same region. Reading the control register returns the card interrupt flag. Reading the data slot returns the card data latch.

Every select and strobe is combinational from the bus inputs and is qualified by the phase-2 clock. Register contents change on the system clock edge while a write strobe is high. No pin carries a flow of data, so no port uses a valid/ready handshake and nothing applies back-pressure.

Top module: `pxd_top`

## Requirements
- R1: While `rst_n` is low, the block clears the control, page and offset registers. After reset the device is off, `rom_page` is 0, `ram_page` is 0 and `math_rom_off` is 0.
- R2: While `phi2` is low, every window select, every register strobe and `rd_oe` is 0.
- R3: While the device is on and `phi2` is high, an address in $D800–$DBFF raises `rom_sel`, and `rom_page` equals page register bits 6..4.
- R4: While the device is on and `phi2` is high, an address in $DC00–$DDFF raises `ram_sel`, and `ram_page` equals page register bit 7.
- R5: While the device is on and `phi2` is high, an address in $DE00–$DEFF raises `io_sel`. Whenever host A8 is 0, `card_addr` is {4'b0, offset[7:0], host A7..A0}.
- R6: While the device is on and `phi2` is high, an address in $DF00–$DFFF raises `mem_sel`. Whenever host A8 is 1, `card_addr` is {page[3:0], offset[7:0], host A7..A0}.
- R7: While the device is off, none of `rom_sel`, `ram_sel`, `io_sel` and `mem_sel` is raised for any address. At most one of them is ever high.
- R8: The register slots live in page $D1. Only A1..A0 select the slot: 3 is control, 2 is page, 1 is offset, 0 is data. So every slot repeats at each $D1x offset.
- R9: A write (`rw`=0) to the control slot sets the device-on bit from `wdata` bit 0, whether or not the device is on. Writes to the page and offset slots take effect only while the device is on. An access with `rw`=1 changes no register.
- R10: A read of the control slot raises `stat_rd` and returns {7'b0, `card_irq`}. A read of the data slot while the device is on raises `data_rd` and returns `card_data`. `rd_oe` is high exactly for these reads, and `rd_data` is 0 at all other times.
- R11: `math_rom_off` is high exactly while the device-on bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that updates the registers |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Host phase-2 clock; qualifies all decodes |
| addr | input | 16 | Host address |
| rw | input | 1 | 1 = host read, 0 = host write |
| wdata | input | 8 | Host write data |
| card_data | input | 8 | Card data latch contents |
| card_irq | input | 1 | Latched card interrupt flag |
| rom_sel | output | 1 | Driver ROM select |
| ram_sel | output | 1 | Scratch RAM select |
| io_sel | output | 1 | Card I/O window select |
| mem_sel | output | 1 | Card memory window select |
| rom_page | output | 3 | ROM page (upper ROM address bits) |
| ram_page | output | 1 | RAM page (upper RAM address bit) |
| card_addr | output | 20 | Full card address |
| ctrl_wr | output | 1 | Control register write strobe |
| page_wr | output | 1 | Page register write strobe |
| ofs_wr | output | 1 | Offset register write strobe |
| data_rd | output | 1 | Card data latch read strobe |
| stat_rd | output | 1 | Control/status read strobe |
| rd_oe | output | 1 | Block drives host read data |
| rd_data | output | 8 | Host read data |
| math_rom_off | output | 1 | Tells the host to disable its math ROM |

## Verification
The assertions assume that `addr`, `rw` and `wdata` are stable around each rising `clk` edge. They also assume that `phi2` is an ordinary level input sampled on that clock, not a second clock. The bench meets both assumptions by changing every input only on the falling edge and by drawing `phi2` as a random level for each cycle.

The random addresses are weighted toward page $D1 and the $D8–$DF region, so every slot mirror and every window is hit. The device-on bit is switched on and off often, so each window is tried in both states. Reads and writes aimed at the register slots are mixed, so writes with `rw`=1 and writes made while the device is off are both tried.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
  // Register slot numbers taken from host A1..A0
  localparam logic [1:0] SLOT_DATA = 2'd0;
  localparam logic [1:0] SLOT_OFS  = 2'd1;
  localparam logic [1:0] SLOT_PAGE = 2'd2;
  localparam logic [1:0] SLOT_CTRL = 2'd3;

  typedef struct packed {
    logic ctrl_wr;
    logic page_wr;
    logic ofs_wr;
    logic data_rd;
    logic stat_rd;
  } pxd_strobe_t;

  typedef struct packed {
    logic rom;
    logic ram;
    logic io;
    logic mem;
  } pxd_win_t;
endpackage

// File: rtl/pxd_reg_decode.sv
module pxd_reg_decode
  import pxd_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [7:0]  REG_PAGE = 8'hD1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi2,
  input  logic [AW-1:0] addr,
  input  logic          rw,
  input  logic          dev_on,
  output pxd_strobe_t   stb
);
  logic       hit;
  logic [1:0] slot;

  assign hit  = phi2 && (addr[AW-1:AW-8] == REG_PAGE);
  assign slot = addr[1:0];

  always_comb begin
    stb = '0;
    if (hit) begin
      stb.ctrl_wr = !rw && (slot == SLOT_CTRL);
      stb.page_wr = !rw && (slot == SLOT_PAGE) && dev_on;
      stb.ofs_wr  = !rw && (slot == SLOT_OFS)  && dev_on;
      stb.data_rd =  rw && (slot == SLOT_DATA) && dev_on;
      stb.stat_rd =  rw && (slot == SLOT_CTRL);
    end
  end

  // R2
  strobe_phi2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> (stb == '0));
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
endmodule

// File: rtl/pxd_win_decode.sv
module pxd_win_decode
  import pxd_pkg::*;
#(
  parameter int         AW       = 16,
  parameter logic [4:0] WIN_BASE = 5'b11011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi2,
  input  logic [AW-1:0] addr,
  input  logic          dev_on,
  output pxd_win_t      win
);
  localparam int TOP = AW - 1;

  logic in_region;
  assign in_region = phi2 && dev_on && (addr[TOP:TOP-4] == WIN_BASE);

  always_comb begin
    win     = '0;
    win.rom = in_region && !addr[10];
    win.ram = in_region && (addr[10:9] == 2'b10);
    win.io  = in_region && (addr[10:8] == 3'b110);
    win.mem = in_region && (addr[10:8] == 3'b111);
  end

  // R7
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));
  // R7
  win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_on |-> (win == '0));
endmodule

// File: rtl/pxd_regs.sv
module pxd_regs
  import pxd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pxd_strobe_t   stb,
  input  logic [DW-1:0] wdata,
  output logic          dev_on,
  output logic [DW-1:0] page_q,
  output logic [DW-1:0] ofs_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_on <= 1'b0;
      page_q <= '0;
      ofs_q  <= '0;
    end else begin
      if (stb.ctrl_wr) dev_on <= wdata[0];
      if (stb.page_wr) page_q <= wdata;
      if (stb.ofs_wr)  ofs_q  <= wdata;
    end
  end

  // R9
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.page_wr |=> $stable(page_q));
  // R9
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.ofs_wr |=> $stable(ofs_q));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!dev_on && page_q == '0 && ofs_q == '0));
endmodule

// File: rtl/pxd_top.sv
module pxd_top
  import pxd_pkg::*;
#(
  parameter int         AW       = 16,
  parameter int         DW       = 8,
  parameter int         CAW      = 20,
  parameter logic [7:0] REG_PAGE = 8'hD1,
  parameter logic [4:0] WIN_BASE = 5'b11011
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           phi2,
  input  logic [AW-1:0]  addr,
  input  logic           rw,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  card_data,
  input  logic           card_irq,
  output logic           rom_sel,
  output logic           ram_sel,
  output logic           io_sel,
  output logic           mem_sel,
  output logic [2:0]     rom_page,
  output logic           ram_page,
  output logic [CAW-1:0] card_addr,
  output logic           ctrl_wr,
  output logic           page_wr,
  output logic           ofs_wr,
  output logic           data_rd,
  output logic           stat_rd,
  output logic           rd_oe,
  output logic [DW-1:0]  rd_data,
  output logic           math_rom_off
);
  localparam int HIW = CAW - 16;

  pxd_strobe_t    stb;
  pxd_win_t       win;
  logic           dev_on;
  logic [DW-1:0]  page_q;
  logic [DW-1:0]  ofs_q;

  pxd_reg_decode #(.AW(AW), .REG_PAGE(REG_PAGE)) u_rdec (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr), .rw(rw),
    .dev_on(dev_on), .stb(stb)
  );

  pxd_win_decode #(.AW(AW), .WIN_BASE(WIN_BASE)) u_wdec (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr),
    .dev_on(dev_on), .win(win)
  );

  pxd_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(wdata),
    .dev_on(dev_on), .page_q(page_q), .ofs_q(ofs_q)
  );

  assign rom_sel  = win.rom;
  assign ram_sel  = win.ram;
  assign io_sel   = win.io;
  assign mem_sel  = win.mem;
  assign rom_page = page_q[6:4];
  assign ram_page = page_q[7];

  // Host A8 picks the I/O form (no high bits) or the memory form
  assign card_addr = addr[8] ? {page_q[HIW-1:0], ofs_q, addr[7:0]}
                             : {{HIW{1'b0}}, ofs_q, addr[7:0]};

  assign ctrl_wr = stb.ctrl_wr;
  assign page_wr = stb.page_wr;
  assign ofs_wr  = stb.ofs_wr;
  assign data_rd = stb.data_rd;
  assign stat_rd = stb.stat_rd;

  always_comb begin
    rd_oe   = stb.data_rd | stb.stat_rd;
    rd_data = '0;
    if (stb.data_rd)      rd_data = card_data;
    else if (stb.stat_rd) rd_data = {{(DW-1){1'b0}}, card_irq};
  end

  assign math_rom_off = dev_on;

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));
  // R11
  math_off_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel | ram_sel | io_sel | mem_sel) |-> math_rom_off);
  // R9
  ctrl_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (math_rom_off == $past(wdata[0])));
endmodule

// File: tb/pxd_top_test.sv
module pxd_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0;
  logic [15:0] addr = '0;
  logic        rw = 1'b1;
  logic [7:0]  wdata = '0;
  logic [7:0]  card_data = '0;
  logic        card_irq = 1'b0;
  logic        rom_sel, ram_sel, io_sel, mem_sel, ram_page;
  logic [2:0]  rom_page;
  logic [19:0] card_addr;
  logic        ctrl_wr, page_wr, ofs_wr, data_rd, stat_rd, rd_oe, math_rom_off;
  logic [7:0]  rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  bit       m_on = 0;
  bit [7:0] m_page = 0;
  bit [7:0] m_ofs = 0;

  always #5 clk = ~clk;

  pxd_top uut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr), .rw(rw),
    .wdata(wdata), .card_data(card_data), .card_irq(card_irq),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .io_sel(io_sel), .mem_sel(mem_sel),
    .rom_page(rom_page), .ram_page(ram_page), .card_addr(card_addr),
    .ctrl_wr(ctrl_wr), .page_wr(page_wr), .ofs_wr(ofs_wr),
    .data_rd(data_rd), .stat_rd(stat_rd), .rd_oe(rd_oe), .rd_data(rd_data),
    .math_rom_off(math_rom_off)
  );

  function automatic logic [63:0] got_vec();
    return {21'd0, rom_sel, ram_sel, io_sel, mem_sel, rom_page, ram_page,
            card_addr, ctrl_wr, page_wr, ofs_wr, data_rd, stat_rd,
            rd_oe, rd_data, math_rom_off};
  endfunction

  function automatic logic [63:0] exp_vec();
    bit reg_hit, reg_q, win_q;
    bit e_rom, e_ram, e_io, e_mem, cw, pw, ow, dr, sr;
    bit [19:0] ca;
    bit [7:0] rd;
    reg_hit = (addr[15:8] == 8'hD1);
    reg_q = phi2 && reg_hit;
    win_q = phi2 && m_on && (addr[15:11] == 5'b11011);
    e_rom = win_q && (addr[10] == 1'b0);
    e_ram = win_q && (addr[10:9] == 2'b10);
    e_io  = win_q && (addr[10:8] == 3'b110);
    e_mem = win_q && (addr[10:8] == 3'b111);
    cw = reg_q && !rw && addr[1:0] == 2'd3;
    pw = reg_q && !rw && addr[1:0] == 2'd2 && m_on;
    ow = reg_q && !rw && addr[1:0] == 2'd1 && m_on;
    dr = reg_q && rw && addr[1:0] == 2'd0 && m_on;
    sr = reg_q && rw && addr[1:0] == 2'd3;
    ca = addr[8] ? {m_page[3:0], m_ofs, addr[7:0]} : {4'd0, m_ofs, addr[7:0]};
    rd = dr ? card_data : (sr ? {7'd0, card_irq} : 8'd0);
    return {21'd0, e_rom, e_ram, e_io, e_mem, m_page[6:4], m_page[7], ca,
            cw, pw, ow, dr, sr, dr | sr, rd, m_on};
  endfunction

  function automatic string req_tag();
    if (!phi2) return "R2";
    if (addr[15:8] == 8'hD1) return rw ? "R10" : "R9";
    if (addr[15:11] == 5'b11011) begin
      if (!m_on) return "R7";
      if (!addr[10]) return "R3";
      if (!addr[9]) return "R4";
      return addr[8] ? "R6" : "R5";
    end
    return "R11";
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h addr=%h rw=%b phi2=%b", req, got, exp,
               addr, rw, phi2);
    end
  endtask

  // one bus cycle: drive at falling edge, check, then model the edge
  task automatic cycle(bit p, logic [15:0] a, bit r, logic [7:0] d, string req);
    @(negedge clk);
    phi2 = p; addr = a; rw = r; wdata = d;
    card_data = 8'($urandom); card_irq = 1'($urandom);
    #1;
    check(req == "" ? req_tag() : req, got_vec(), exp_vec());
    @(posedge clk);
    if (p && a[15:8] == 8'hD1 && !r) begin
      if (a[1:0] == 2'd3) m_on = d[0];
      else if (a[1:0] == 2'd2 && m_on) m_page = d;
      else if (a[1:0] == 2'd1 && m_on) m_ofs = d;
    end
  endtask

  function automatic logic [15:0] rand_addr();
    int k = $urandom_range(0, 9);
    if (k < 4) return {8'hD1, 8'($urandom)};
    if (k < 8) return {5'b11011, 11'($urandom)};
    return 16'($urandom);
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    phi2 = 1'b1; addr = 16'hDF10; rw = 1'b1;
    #1;
    // R1: reset state, device off, pages zero
    check("R1", {61'd0, math_rom_off, rom_page == 3'd0, ram_page}, 64'd2);
    rst_n = 1'b1;

    // R7: windows closed before enabling
    cycle(1, 16'hD800, 1, 8'h00, "R7");
    // R9: page write ignored while off
    cycle(1, 16'hD1FE, 0, 8'hFF, "R9");
    cycle(1, 16'hD900, 1, 8'h00, "R9");
    // R9/R11: enable via control slot
    cycle(1, 16'hD1FF, 0, 8'h01, "R9");
    cycle(1, 16'hD000, 1, 8'h00, "R11");
    // R8: mirror writes at other $D1x offsets
    cycle(1, 16'hD126, 0, 8'hB5, "R8");
    cycle(1, 16'hD1A1, 0, 8'h3C, "R8");
    // R9: rw=1 on page slot changes nothing
    cycle(1, 16'hD1FE, 1, 8'h00, "R9");
    cycle(1, 16'hDBFF, 1, 8'h00, "R3");
    cycle(1, 16'hDC00, 1, 8'h00, "R4");
    cycle(1, 16'hDDFF, 1, 8'h00, "R4");
    cycle(1, 16'hDE7F, 0, 8'h00, "R5");
    cycle(1, 16'hDFC3, 1, 8'h00, "R6");
    cycle(0, 16'hDF00, 1, 8'h00, "R2");
    cycle(1, 16'hD1FC, 1, 8'h00, "R10");
    cycle(1, 16'hD1F3, 1, 8'h00, "R10");
    cycle(1, 16'hD7FF, 1, 8'h00, "R11");
    cycle(1, 16'hE000, 1, 8'h00, "R11");

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a = rand_addr();
      logic [7:0]  d = 8'($urandom);
      if (a[15:8] == 8'hD1 && a[1:0] == 2'd3) d[0] = ($urandom_range(0, 9) < 7);
      cycle($urandom_range(0, 3) != 0, a, 1'($urandom), d, "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule